// File: doc/BRIEF.md
# Multichannel Voice Command Interface

This block is the host-side command front end of an eight-channel sample playback engine. A host writes bytes either over an 8-bit parallel bus (chip select plus write strobe) or, when the serial strap is high, bit by bit over two lines of that same bus. Bit 7 carries the data and bit 6 carries the shift clock. A command/operand select line tags each byte. An operand byte is held as the pending operand. A command byte then acts on that operand: it can copy it into the global option register, store it as the phrase address of one channel, or start every channel whose bit is set in it.

The block keeps a busy flag for each channel and a flag that shows whether a phrase address has been loaded since that channel last started. The playback engine reports the end of each phrase on its own input. The host can read channel status as a full byte on the parallel bus. In serial mode it reads the status as a four-channel nibble and chooses the upper or lower half. A mode input selects which status is shown: busy, or not-ready. Decoding, mixing, conversion and memory addressing are not part of this block.

Top module: `voice_cmd_front`

## Requirements
- R1: After reset the option register, all phrase addresses and the start pulses are 0, every busy flag is 0, and every not-ready flag is 1.
- R2: A committed byte with `cmd_sel` high becomes the pending operand and changes neither the option register nor any phrase address.
- R3: While `cs_n` is high, write strobes are ignored: no operand, option, phrase or start changes.
- R4: Command 18h copies the pending operand into `option` at the clock edge where the write strobe rise is seen.
- R5: Commands 28h..2Fh copy the pending operand into the phrase address of channel (opcode bits [2:0]) + 1. Channel k (0-based) occupies `phrase_addr[8k+7:8k]`.
- R6: Command 00h raises `start_pulse` for exactly one cycle, with bit k set where bit k of the pending operand is set (bit 0 is channel 1), and sets the matching busy flags.
- R7: A busy flag clears one edge after its `phrase_end` bit is seen high. A start in the same cycle takes priority and leaves the flag set.
- R8: Any opcode other than 00h, 18h and 28h..2Fh leaves option, phrase addresses, busy flags and start pulses unchanged.
- R9: In serial mode a byte is shifted MSB first on rising edges of bus bit 6 while `cs_n` is low. It is committed on the write strobe rise only if exactly 8 shift edges came before it. Otherwise it is discarded.
- R10: In parallel mode, with `cs_n` and `rd_n` low, `bus_oe` is 1 and `bus_out` carries the status byte, bit k for channel k+1. Otherwise `bus_oe` is 0.
- R11: `ser_status` shows status bits [7:4] when `nib_upper` is 1 and bits [3:0] when it is 0.
- R12: With `stat_mode` 0 the status is the busy flags. With `stat_mode` 1 a channel is not-ready when it is busy or has had no phrase address load since its last start or reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| serial_sel | input | 1 | 1 selects serial input on bus bits 7/6 |
| cs_n | input | 1 | Chip select, active low |
| wr_n | input | 1 | Write strobe, byte commits on rising edge |
| rd_n | input | 1 | Read strobe, active low |
| cmd_sel | input | 1 | 1 = operand byte, 0 = command byte |
| bus_in | input | 8 | Host bus input (serial data on bit 7, shift clock on bit 6) |
| bus_out | output | 8 | Status byte for parallel reads |
| bus_oe | output | 1 | Bus output enable |
| nib_upper | input | 1 | Selects the upper status nibble in serial mode |
| stat_mode | input | 1 | 1 = not-ready status, 0 = busy status |
| ser_status | output | 4 | Serial-mode status nibble |
| phrase_end | input | 8 | End-of-phrase report per channel from the engine |
| start_pulse | output | 8 | One-cycle start per channel |
| phrase_addr | output | 64 | Phrase address per channel, 8 bits each |
| option | output | 8 | Global option register |

## Verification
The assertions assume that all inputs, including the strobes and the serial clock, are synchronous to `clk`. They also assume that every write strobe stays low for at least one cycle, so two commits never fall on adjacent edges. The bench drives every input on the falling clock edge and holds each strobe level for a full cycle, so each rise is seen exactly once. It keeps `cs_n` and `cmd_sel` steady across each strobe rise, so the select values sampled at the commit edge are the ones the stimulus intended.

// File: rtl/voice_cmd_pkg.sv
package voice_cmd_pkg;

    localparam int NUM_CH = 8;
    localparam int BYTE_W = 8;

    localparam logic [BYTE_W-1:0] OP_START       = 8'h00;
    localparam logic [BYTE_W-1:0] OP_OPTION      = 8'h18;
    localparam logic [BYTE_W-1:0] OP_PHRASE_BASE = 8'h28;

    typedef enum logic [1:0] {
        CMD_NONE,
        CMD_OPTION,
        CMD_PHRASE,
        CMD_START
    } cmd_kind_e;

    typedef struct packed {
        cmd_kind_e  kind;
        logic [2:0] chan;
    } cmd_dec_t;

    typedef struct packed {
        logic              valid;
        logic              is_sub;
        logic [BYTE_W-1:0] data;
    } host_byte_t;

    function automatic cmd_dec_t decode_op(input logic [BYTE_W-1:0] op);
        cmd_dec_t d;
        d.chan = op[2:0];
        if (op == OP_START)
            d.kind = CMD_START;
        else if (op == OP_OPTION)
            d.kind = CMD_OPTION;
        else if (op[BYTE_W-1:3] == OP_PHRASE_BASE[BYTE_W-1:3])
            d.kind = CMD_PHRASE;
        else
            d.kind = CMD_NONE;
        return d;
    endfunction

endpackage

// File: rtl/vc_byte_capture.sv
module vc_byte_capture
    import voice_cmd_pkg::*;
#(
    parameter int BW = BYTE_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          serial_sel,
    input  logic          cs_n,
    input  logic          wr_n,
    input  logic          cmd_sel,
    input  logic [BW-1:0] bus_in,
    output host_byte_t    hb
);
    localparam int CNT_W = $clog2(BW + 2);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(BW);
    localparam logic [CNT_W-1:0] CNT_OVER = CNT_W'(BW + 1);

    logic          wr_q;
    logic          sclk_q;
    logic [BW-1:0] par_lat;
    logic [BW-1:0] shreg;
    logic [CNT_W-1:0] bit_cnt;
    logic          wr_rise;
    logic          sclk_rise;

    assign wr_rise   = wr_n & ~wr_q;
    assign sclk_rise = serial_sel & ~cs_n & bus_in[BW-2] & ~sclk_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_q    <= 1'b1;
            sclk_q  <= 1'b0;
            par_lat <= '0;
            shreg   <= '0;
            bit_cnt <= '0;
        end else begin
            wr_q   <= wr_n;
            sclk_q <= bus_in[BW-2];
            if (!wr_n)
                par_lat <= bus_in;
            if (wr_rise) begin
                bit_cnt <= '0;
            end else if (sclk_rise) begin
                shreg <= {shreg[BW-2:0], bus_in[BW-1]};
                if (bit_cnt != CNT_OVER)
                    bit_cnt <= bit_cnt + 1'b1;
            end
        end
    end

    always_comb begin
        hb.valid  = wr_rise & ~cs_n & (~serial_sel | (bit_cnt == CNT_FULL));
        hb.is_sub = cmd_sel;
        hb.data   = serial_sel ? shreg : par_lat;
    end

endmodule

// File: rtl/vc_cmd_exec.sv
module vc_cmd_exec
    import voice_cmd_pkg::*;
#(
    parameter int NCH = NUM_CH,
    parameter int BW  = BYTE_W
) (
    input  logic              clk,
    input  logic              rst,
    input  host_byte_t        hb,
    output logic [BW-1:0]     option,
    output logic [NCH*BW-1:0] phrase_addr,
    output logic [NCH-1:0]    load_req,
    output logic [NCH-1:0]    start_req,
    output logic [NCH-1:0]    start_pulse
);
    logic [BW-1:0] pending;
    logic [BW-1:0] phr_q [NCH];
    cmd_dec_t      dec;
    logic          is_cmd;

    assign dec    = decode_op(hb.data);
    assign is_cmd = hb.valid & ~hb.is_sub;

    always_comb begin
        start_req = '0;
        if (is_cmd && dec.kind == CMD_START)
            start_req = pending[NCH-1:0];
    end

    generate
        for (genvar k = 0; k < NCH; k++) begin : g_chan
            assign load_req[k] = is_cmd && (dec.kind == CMD_PHRASE) && (dec.chan == 3'(k));
            always_ff @(posedge clk) begin
                if (rst)
                    phr_q[k] <= '0;
                else if (load_req[k])
                    phr_q[k] <= pending;
            end
            assign phrase_addr[k*BW +: BW] = phr_q[k];
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            pending     <= '0;
            option      <= '0;
            start_pulse <= '0;
        end else begin
            start_pulse <= start_req;
            if (hb.valid && hb.is_sub)
                pending <= hb.data;
            if (is_cmd && dec.kind == CMD_OPTION)
                option <= pending;
        end
    end

endmodule

// File: rtl/vc_chan_status.sv
module vc_chan_status
    import voice_cmd_pkg::*;
#(
    parameter int NCH = NUM_CH
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [NCH-1:0]   start_req,
    input  logic [NCH-1:0]   load_req,
    input  logic [NCH-1:0]   phrase_end,
    input  logic             stat_mode,
    input  logic             serial_sel,
    input  logic             cs_n,
    input  logic             rd_n,
    input  logic             nib_upper,
    output logic [NCH-1:0]   busy,
    output logic [NCH-1:0]   bus_out,
    output logic             bus_oe,
    output logic [NCH/2-1:0] ser_status
);
    localparam int NIB = NCH / 2;

    logic [NCH-1:0] loaded;
    logic [NCH-1:0] stat;

    generate
        for (genvar k = 0; k < NCH; k++) begin : g_flag
            always_ff @(posedge clk) begin
                if (rst) begin
                    busy[k]   <= 1'b0;
                    loaded[k] <= 1'b0;
                end else begin
                    if (start_req[k])
                        busy[k] <= 1'b1;
                    else if (phrase_end[k])
                        busy[k] <= 1'b0;
                    if (start_req[k])
                        loaded[k] <= 1'b0;
                    else if (load_req[k])
                        loaded[k] <= 1'b1;
                end
            end
            assign stat[k] = stat_mode ? (busy[k] | ~loaded[k]) : busy[k];
        end
    endgenerate

    assign bus_out    = stat;
    assign bus_oe     = ~serial_sel & ~cs_n & ~rd_n;
    assign ser_status = nib_upper ? stat[NCH-1:NIB] : stat[NIB-1:0];

endmodule

// File: rtl/voice_cmd_front.sv
module voice_cmd_front
    import voice_cmd_pkg::*;
#(
    parameter int NCH = NUM_CH,
    parameter int BW  = BYTE_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              serial_sel,
    input  logic              cs_n,
    input  logic              wr_n,
    input  logic              rd_n,
    input  logic              cmd_sel,
    input  logic [BW-1:0]     bus_in,
    output logic [NCH-1:0]    bus_out,
    output logic              bus_oe,
    input  logic              nib_upper,
    input  logic              stat_mode,
    output logic [NCH/2-1:0]  ser_status,
    input  logic [NCH-1:0]    phrase_end,
    output logic [NCH-1:0]    start_pulse,
    output logic [NCH*BW-1:0] phrase_addr,
    output logic [BW-1:0]     option
);
    host_byte_t     hb;
    logic [NCH-1:0] load_req;
    logic [NCH-1:0] start_req;
    logic [NCH-1:0] busy_vec;

    vc_byte_capture #(.BW(BW)) u_capture (
        .clk        (clk),
        .rst        (rst),
        .serial_sel (serial_sel),
        .cs_n       (cs_n),
        .wr_n       (wr_n),
        .cmd_sel    (cmd_sel),
        .bus_in     (bus_in),
        .hb         (hb)
    );

    vc_cmd_exec #(.NCH(NCH), .BW(BW)) u_exec (
        .clk         (clk),
        .rst         (rst),
        .hb          (hb),
        .option      (option),
        .phrase_addr (phrase_addr),
        .load_req    (load_req),
        .start_req   (start_req),
        .start_pulse (start_pulse)
    );

    vc_chan_status #(.NCH(NCH)) u_status (
        .clk        (clk),
        .rst        (rst),
        .start_req  (start_req),
        .load_req   (load_req),
        .phrase_end (phrase_end),
        .stat_mode  (stat_mode),
        .serial_sel (serial_sel),
        .cs_n       (cs_n),
        .rd_n       (rd_n),
        .nib_upper  (nib_upper),
        .busy       (busy_vec),
        .bus_out    (bus_out),
        .bus_oe     (bus_oe),
        .ser_status (ser_status)
    );

endmodule

// File: rtl/voice_cmd_checker.sv
module voice_cmd_checker #(
    parameter int NCH = 8,
    parameter int BW  = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              cs_n,
    input logic              cmd_sel,
    input logic [NCH-1:0]    phrase_end,
    input logic [NCH-1:0]    start_pulse,
    input logic [NCH*BW-1:0] phrase_addr,
    input logic [BW-1:0]     option,
    input logic [NCH-1:0]    busy
);
    AST_CS_GATE: assert property (@(posedge clk) disable iff (rst)
        cs_n |=> ($stable(option) && $stable(phrase_addr) && start_pulse == '0)); // R3

    AST_OPERAND_ONLY: assert property (@(posedge clk) disable iff (rst)
        cmd_sel |=> ($stable(option) && $stable(phrase_addr))); // R2

    AST_START_SINGLE: assert property (@(posedge clk) disable iff (rst)
        (start_pulse != '0) |=> (start_pulse == '0)); // R6

    AST_START_BUSY: assert property (@(posedge clk) disable iff (rst)
        ((start_pulse & ~busy) == '0)); // R6

    AST_END_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (phrase_end != '0) |=> ((busy & $past(phrase_end) & ~start_pulse) == '0)); // R7
endmodule

bind voice_cmd_front voice_cmd_checker #(.NCH(NCH), .BW(BW)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .cs_n        (cs_n),
    .cmd_sel     (cmd_sel),
    .phrase_end  (phrase_end),
    .start_pulse (start_pulse),
    .phrase_addr (phrase_addr),
    .option      (option),
    .busy        (busy_vec)
);

// File: tb/voice_cmd_front_bench.sv
module voice_cmd_front_bench;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        serial_sel = 1'b0, cs_n = 1'b1, wr_n = 1'b1, rd_n = 1'b1, cmd_sel = 1'b0;
    logic [7:0]  bus_in = '0;
    logic [7:0]  bus_out;
    logic        bus_oe;
    logic        nib_upper = 1'b0, stat_mode = 1'b0;
    logic [3:0]  ser_status;
    logic [7:0]  phrase_end = '0;
    logic [7:0]  start_pulse;
    logic [63:0] phrase_addr;
    logic [7:0]  option;

    int tests = 0, fails = 0;
    bit done = 0;
    logic [63:0] exp_phr = '0;
    logic [7:0]  exp_loaded = '0;
    logic [7:0]  exp_opt = '0;
    logic [7:0]  v8;
    logic        oe;

    always #(CLK_PERIOD/2) clk = ~clk;

    voice_cmd_front u_voice_cmd_front (
        .clk(clk), .rst(rst), .serial_sel(serial_sel), .cs_n(cs_n), .wr_n(wr_n),
        .rd_n(rd_n), .cmd_sel(cmd_sel), .bus_in(bus_in), .bus_out(bus_out),
        .bus_oe(bus_oe), .nib_upper(nib_upper), .stat_mode(stat_mode),
        .ser_status(ser_status), .phrase_end(phrase_end), .start_pulse(start_pulse),
        .phrase_addr(phrase_addr), .option(option)
    );

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic par_write(input bit sub, input logic [7:0] d, input bit csn);
        @(negedge clk); cs_n = csn; cmd_sel = sub; bus_in = d; wr_n = 1'b0;
        @(negedge clk); wr_n = 1'b1;
        @(negedge clk); cs_n = 1'b1;
    endtask

    task automatic ser_write(input bit sub, input logic [7:0] d, input int nbits);
        @(negedge clk); cs_n = 1'b0; cmd_sel = sub; wr_n = 1'b1; bus_in = '0;
        for (int i = 0; i < nbits; i++) begin
            @(negedge clk); bus_in[7] = (i < 8) ? d[7-i] : 1'b0; bus_in[6] = 1'b0;
            @(negedge clk); bus_in[6] = 1'b1;
        end
        @(negedge clk); bus_in[6] = 1'b0; wr_n = 1'b0;
        @(negedge clk); wr_n = 1'b1;
        @(negedge clk); cs_n = 1'b1;
    endtask

    task automatic rd_status(output logic [7:0] v, output logic e);
        @(negedge clk); cs_n = 1'b0; rd_n = 1'b0;
        #1; v = bus_out; e = bus_oe;
        rd_n = 1'b1; cs_n = 1'b1;
    endtask

    task automatic end_phrases(input logic [7:0] m);
        @(negedge clk); phrase_end = m;
        @(negedge clk); phrase_end = '0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            tests++; fails++;
            $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk(option == 8'h00, "R1 option", option, 0);
        chk(phrase_addr == '0, "R1 phrase", phrase_addr, 0);
        chk(start_pulse == '0, "R1 start", start_pulse, 0);
        stat_mode = 1'b0; rd_status(v8, oe);
        chk(v8 == 8'h00, "R1 busy", v8, 0);
        stat_mode = 1'b1; rd_status(v8, oe);
        chk(v8 == 8'hFF, "R1 notready", v8, 8'hFF);

        // R2 and R4: full sweep of option values
        for (int v = 0; v < 256; v++) begin
            par_write(1'b1, 8'(v), 1'b0);
            chk(option == exp_opt, "R2 operand no option change", option, exp_opt);
            par_write(1'b0, 8'h18, 1'b0);
            exp_opt = 8'(v);
            chk(option == exp_opt, "R4 option load", option, exp_opt);
        end

        // R5 phrase loads per channel
        for (int k = 0; k < 8; k++) begin
            v8 = 8'((k * 37 + 11) & 8'hFF);
            par_write(1'b1, v8, 1'b0);
            chk(phrase_addr == exp_phr, "R2 operand no phrase change", phrase_addr, exp_phr);
            par_write(1'b0, 8'h28 + 8'(k), 1'b0);
            exp_phr[k*8 +: 8] = v8;
            exp_loaded[k] = 1'b1;
            chk(phrase_addr == exp_phr, "R5 phrase load", phrase_addr, exp_phr);
        end
        stat_mode = 1'b1; rd_status(v8, oe);
        chk(v8 == ~exp_loaded, "R12 notready after loads", v8, ~exp_loaded);

        // R6, R7, R12: every start mask
        for (int m = 0; m < 256; m++) begin
            par_write(1'b1, 8'(m), 1'b0);
            par_write(1'b0, 8'h00, 1'b0);
            chk(start_pulse == 8'(m), "R6 start pulse", start_pulse, m);
            @(negedge clk);
            chk(start_pulse == 8'h00, "R6 pulse one cycle", start_pulse, 0);
            exp_loaded = exp_loaded & ~8'(m);
            stat_mode = 1'b0; rd_status(v8, oe);
            chk(v8 == 8'(m), "R6 busy set", v8, m);
            end_phrases(8'(m));
            rd_status(v8, oe);
            chk(v8 == 8'h00, "R7 busy cleared", v8, 0);
            stat_mode = 1'b1; rd_status(v8, oe);
            chk(v8 == ~exp_loaded, "R12 notready", v8, ~exp_loaded);
        end
        chk(phrase_addr == exp_phr, "R6 phrases kept", phrase_addr, exp_phr);

        // R12: reload channel 3 then start it
        par_write(1'b1, 8'h77, 1'b0); par_write(1'b0, 8'h2A, 1'b0);
        exp_phr[2*8 +: 8] = 8'h77;
        stat_mode = 1'b1; rd_status(v8, oe);
        chk(v8 == 8'hFB, "R12 ready after reload", v8, 8'hFB);
        par_write(1'b1, 8'h04, 1'b0); par_write(1'b0, 8'h00, 1'b0);
        stat_mode = 1'b0; rd_status(v8, oe);
        chk(v8 == 8'h04, "R12 busy view", v8, 8'h04);
        stat_mode = 1'b1; rd_status(v8, oe);
        chk(v8 == 8'hFF, "R12 notready view", v8, 8'hFF);
        end_phrases(8'h04);

        // R7 start wins over same-cycle end
        par_write(1'b1, 8'h01, 1'b0);
        @(negedge clk); cs_n = 1'b0; cmd_sel = 1'b0; bus_in = 8'h00; wr_n = 1'b0;
        @(negedge clk); wr_n = 1'b1; phrase_end = 8'h01;
        @(negedge clk); cs_n = 1'b1; phrase_end = 8'h00;
        stat_mode = 1'b0; rd_status(v8, oe);
        chk(v8 == 8'h01, "R7 start priority", v8, 8'h01);
        end_phrases(8'h01);
        rd_status(v8, oe);
        chk(v8 == 8'h00, "R7 later end clears", v8, 0);

        // R8 undefined opcodes
        par_write(1'b1, 8'hFF, 1'b0);
        for (int op = 0; op < 256; op++) begin
            if (op == 8'h00 || op == 8'h18 || (op >= 8'h28 && op <= 8'h2F)) continue;
            par_write(1'b0, 8'(op), 1'b0);
            chk(start_pulse == 8'h00 && option == exp_opt && phrase_addr == exp_phr,
                "R8 undefined opcode", {option, start_pulse}, {exp_opt, 8'h00});
        end
        stat_mode = 1'b0; rd_status(v8, oe);
        chk(v8 == 8'h00, "R8 busy untouched", v8, 0);

        // R3 chip select gating
        par_write(1'b1, 8'h3C, 1'b0); par_write(1'b0, 8'h18, 1'b0);
        exp_opt = 8'h3C;
        par_write(1'b1, 8'hAA, 1'b1);
        par_write(1'b0, 8'h18, 1'b1);
        chk(option == exp_opt, "R3 cs high command ignored", option, exp_opt);
        par_write(1'b0, 8'h00, 1'b1);
        chk(start_pulse == 8'h00, "R3 cs high start ignored", start_pulse, 0);
        par_write(1'b0, 8'h18, 1'b0);
        chk(option == 8'h3C, "R3 cs high operand ignored", option, 8'h3C);

        // R10 parallel read enable
        par_write(1'b1, 8'h81, 1'b0); par_write(1'b0, 8'h00, 1'b0);
        stat_mode = 1'b0; rd_status(v8, oe);
        chk(oe == 1'b1 && v8 == 8'h81, "R10 read byte", {oe, v8}, {1'b1, 8'h81});
        @(negedge clk); cs_n = 1'b1; rd_n = 1'b0; #1;
        chk(bus_oe == 1'b0, "R10 no oe without cs", bus_oe, 0);
        rd_n = 1'b1; #1;
        chk(bus_oe == 1'b0, "R10 no oe without rd", bus_oe, 0);
        end_phrases(8'h81);

        // R9 serial writes
        serial_sel = 1'b1;
        for (int i = 0; i < 6; i++) begin
            v8 = 8'((i * 83 + 29) & 8'hFF);
            ser_write(1'b1, v8, 8); ser_write(1'b0, 8'h18, 8);
            exp_opt = v8;
            chk(option == exp_opt, "R9 serial option", option, exp_opt);
        end
        ser_write(1'b1, 8'h5A, 7); ser_write(1'b0, 8'h18, 8);
        chk(option == exp_opt, "R9 short byte discarded", option, exp_opt);
        ser_write(1'b1, 8'hC3, 9); ser_write(1'b0, 8'h18, 8);
        chk(option == exp_opt, "R9 long byte discarded", option, exp_opt);
        ser_write(1'b1, 8'h44, 8); ser_write(1'b0, 8'h2F, 8);
        exp_phr[7*8 +: 8] = 8'h44;
        chk(phrase_addr == exp_phr, "R9 serial phrase", phrase_addr, exp_phr);
        @(negedge clk); cs_n = 1'b0; rd_n = 1'b0; #1;
        chk(bus_oe == 1'b0, "R10 no oe in serial", bus_oe, 0);
        rd_n = 1'b1; cs_n = 1'b1;

        // R11 nibble select
        ser_write(1'b1, 8'hA5, 8); ser_write(1'b0, 8'h00, 8);
        @(negedge clk); stat_mode = 1'b0; nib_upper = 1'b1; #1;
        chk(ser_status == 4'hA, "R11 upper nibble", ser_status, 4'hA);
        nib_upper = 1'b0; #1;
        chk(ser_status == 4'h5, "R11 lower nibble", ser_status, 4'h5);

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule